// File: doc/BRIEF.md
# Switch Egress Port Decoder for Address and ID Routed Packets

Inside a switch built as one upstream bridge feeding several downstream bridges over an internal bus, every memory request, I/O request and completion needs an egress port. This block decides it. For each packet the caller gives a kind code, the upper address bits (memory and I/O requests) and the requester bus number (completions). The window settings that software writes after enumeration are wired straight in as plain vectors. These are the upstream bridge's memory and I/O windows, plus each downstream bridge's memory window, I/O window and secondary-to-subordinate bus range.

A request outside the upstream bridge's window goes back upstream. A request inside the window goes to the downstream bridge whose window holds it. A request inside the upstream window that no downstream bridge claims is flagged unsupported. Completions ignore the address and follow the bus-number ranges only. Memory windows are compared in 1 MB granules and I/O windows in 4 KB granules, and each limit covers its whole granule. A window whose base is above its limit is switched off.

The decode is combinational. One register stage follows it, and that stage presents a valid flag, a one-hot port vector and an unsupported flag.

Top module: `sw_route_dec`

## Requirements
- R1: A memory request (kind 0) whose address bits [31:20] lie in the upstream memory window, and in downstream bridge i's memory window with both bounds inclusive, sets out_port bit i+1.
- R2: An I/O request (kind 1) whose address bits [31:12] lie in the upstream I/O window, and in downstream bridge i's I/O window with both bounds inclusive, sets out_port bit i+1.
- R3: A memory or I/O request whose granule number is outside the upstream window of its kind sets out_port bit 0 (upstream), whatever the downstream windows hold.
- R4: A memory or I/O request inside the upstream window that no enabled downstream window of its kind claims raises out_ur with out_port all zero.
- R5: A completion (kind 2) whose in_bus lies within bridge i's secondary-to-subordinate range, bounds inclusive, sets out_port bit i+1. Otherwise it sets bit 0. A completion is never unsupported, and its address has no effect.
- R6: Any window or bus range whose lower bound exceeds its upper bound matches nothing. A disabled upstream window sends every request of that kind upstream.
- R7: When several downstream bridges match, the lowest-numbered bridge wins.
- R8: Kind 3 is reserved and raises out_ur.
- R9: Results appear one cycle after in_vld. out_vld follows in_vld with that one-cycle delay. When out_vld is high, exactly one of out_port and out_ur is set. When out_vld is low, both are zero.
- R10: While rst_n is low, out_vld, out_port and out_ur are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| in_vld | input | 1 | A packet is presented this cycle |
| in_kind | input | 2 | 0 memory, 1 I/O, 2 completion, 3 reserved |
| in_addr_hi | input | ADDR_W-IO_GRAN_LG (20) | Address bits [31:12] |
| in_bus | input | BUS_W (8) | Requester bus number of a completion |
| up_mem_lo | input | 12 | Upstream memory window base, 1 MB granule number |
| up_mem_hi | input | 12 | Upstream memory window limit, 1 MB granule number |
| up_io_lo | input | 20 | Upstream I/O window base, 4 KB granule number |
| up_io_hi | input | 20 | Upstream I/O window limit, 4 KB granule number |
| dn_mem_lo | input | NUM_DN*12 | Downstream memory bases, bridge i in slice i |
| dn_mem_hi | input | NUM_DN*12 | Downstream memory limits |
| dn_io_lo | input | NUM_DN*20 | Downstream I/O bases |
| dn_io_hi | input | NUM_DN*20 | Downstream I/O limits |
| dn_bus_lo | input | NUM_DN*8 | Downstream secondary bus numbers |
| dn_bus_hi | input | NUM_DN*8 | Downstream subordinate bus numbers |
| out_vld | output | 1 | Registered result valid |
| out_port | output | NUM_DN+1 | One-hot egress: bit 0 upstream, bit i+1 downstream bridge i |
| out_ur | output | 1 | Packet is unsupported |

## Verification
The bench aims at the window edges. It uses the first granule and the very top of the last granule, where a design that compared raw addresses instead of granule numbers would lose the top of the limit granule. It programs overlapping windows to expose a priority that picks the highest index, or sets two port bits at once. It programs reversed windows and reversed bus ranges to catch a design that wraps them into huge ranges. It sends completions whose address hits a memory window to catch decoding by address where bus number is required, and it sends in-window misses to catch a design that returns them upstream rather than flagging them.

// File: rtl/sw_route_pkg.sv
package sw_route_pkg;
  typedef enum logic [1:0] {
    PK_MEM  = 2'd0,
    PK_IO   = 2'd1,
    PK_CPL  = 2'd2,
    PK_RSVD = 2'd3
  } pkt_kind_e;
endpackage

// File: rtl/sw_rng_cmp.sv
// Inclusive range test; a reversed range never matches.
module sw_rng_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] val,
  output logic         hit
);
  always_comb begin
    hit = (lo <= hi) && (val >= lo) && (val <= hi);
  end
endmodule

// File: rtl/sw_first_hit.sv
// Lowest-index selection among matching bridges.
module sw_first_hit #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick,
  output logic         any
);
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        pick[i] = 1'b1;
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sw_route_dec.sv
module sw_route_dec
  import sw_route_pkg::*;
#(
  parameter int NUM_DN      = 4,
  parameter int ADDR_W      = 32,
  parameter int BUS_W       = 8,
  parameter int MEM_GRAN_LG = 20,
  parameter int IO_GRAN_LG  = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_vld,
  input  logic [1:0]                             in_kind,
  input  logic [ADDR_W-IO_GRAN_LG-1:0]           in_addr_hi,
  input  logic [BUS_W-1:0]                       in_bus,
  input  logic [ADDR_W-MEM_GRAN_LG-1:0]          up_mem_lo,
  input  logic [ADDR_W-MEM_GRAN_LG-1:0]          up_mem_hi,
  input  logic [ADDR_W-IO_GRAN_LG-1:0]           up_io_lo,
  input  logic [ADDR_W-IO_GRAN_LG-1:0]           up_io_hi,
  input  logic [NUM_DN*(ADDR_W-MEM_GRAN_LG)-1:0] dn_mem_lo,
  input  logic [NUM_DN*(ADDR_W-MEM_GRAN_LG)-1:0] dn_mem_hi,
  input  logic [NUM_DN*(ADDR_W-IO_GRAN_LG)-1:0]  dn_io_lo,
  input  logic [NUM_DN*(ADDR_W-IO_GRAN_LG)-1:0]  dn_io_hi,
  input  logic [NUM_DN*BUS_W-1:0]                dn_bus_lo,
  input  logic [NUM_DN*BUS_W-1:0]                dn_bus_hi,
  output logic                                   out_vld,
  output logic [NUM_DN:0]                        out_port,
  output logic                                   out_ur
);
  localparam int MW    = ADDR_W - MEM_GRAN_LG;
  localparam int IW    = ADDR_W - IO_GRAN_LG;
  localparam int SHIFT = MEM_GRAN_LG - IO_GRAN_LG;

  pkt_kind_e          kind;
  logic [MW-1:0]      mem_key;
  logic [IW-1:0]      io_key;
  logic               up_mem_hit, up_io_hit;
  logic [NUM_DN-1:0]  mem_hit, io_hit, bus_hit, sel_hit, pick;
  logic               pick_any;
  logic [NUM_DN:0]    dec_port, port_d, port_q;
  logic               dec_ur, ur_d, ur_q, vld_q, en;

  always_comb begin
    kind    = pkt_kind_e'(in_kind);
    io_key  = in_addr_hi;
    mem_key = in_addr_hi[IW-1:SHIFT];
  end

  sw_rng_cmp #(.W(MW)) u_up_mem (
    .lo(up_mem_lo), .hi(up_mem_hi), .val(mem_key), .hit(up_mem_hit));
  sw_rng_cmp #(.W(IW)) u_up_io (
    .lo(up_io_lo), .hi(up_io_hi), .val(io_key), .hit(up_io_hit));

  for (genvar g = 0; g < NUM_DN; g++) begin : g_dn
    sw_rng_cmp #(.W(MW)) u_mem (
      .lo(dn_mem_lo[g*MW +: MW]), .hi(dn_mem_hi[g*MW +: MW]),
      .val(mem_key), .hit(mem_hit[g]));
    sw_rng_cmp #(.W(IW)) u_io (
      .lo(dn_io_lo[g*IW +: IW]), .hi(dn_io_hi[g*IW +: IW]),
      .val(io_key), .hit(io_hit[g]));
    sw_rng_cmp #(.W(BUS_W)) u_bus (
      .lo(dn_bus_lo[g*BUS_W +: BUS_W]), .hi(dn_bus_hi[g*BUS_W +: BUS_W]),
      .val(in_bus), .hit(bus_hit[g]));
  end

  always_comb begin
    unique case (kind)
      PK_MEM:  sel_hit = mem_hit;
      PK_IO:   sel_hit = io_hit;
      PK_CPL:  sel_hit = bus_hit;
      default: sel_hit = '0;
    endcase
  end

  sw_first_hit #(.N(NUM_DN)) u_pick (
    .req(sel_hit), .pick(pick), .any(pick_any));

  // Destination decode
  always_comb begin
    dec_port = '0;
    dec_ur   = 1'b0;
    unique case (kind)
      PK_MEM, PK_IO: begin
        if (!((kind == PK_MEM) ? up_mem_hit : up_io_hit)) dec_port[0] = 1'b1;
        else if (pick_any)                                dec_port[NUM_DN:1] = pick;
        else                                              dec_ur = 1'b1;
      end
      PK_CPL: begin
        if (pick_any) dec_port[NUM_DN:1] = pick;
        else          dec_port[0] = 1'b1;
      end
      default: dec_ur = 1'b1;
    endcase
  end

  // Next state
  always_comb begin
    en     = in_vld | vld_q;
    port_d = in_vld ? dec_port : '0;
    ur_d   = in_vld & dec_ur;
  end

  // Register stage; rst_n arrives already synchronised
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      port_q <= '0;
      ur_q   <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (en) begin
        port_q <= port_d;
        ur_q   <= ur_d;
      end
    end
  end

  assign out_vld  = vld_q;
  assign out_port = port_q;
  assign out_ur   = ur_q;

  p_outside_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && ((kind == PK_MEM && !up_mem_hit) || (kind == PK_IO && !up_io_hit))
    |=> out_port[0] && !out_ur);

  p_cpl_no_ur_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && kind == PK_CPL |=> out_vld && !out_ur);

  p_rsvd_ur_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && kind == PK_RSVD |=> out_ur && out_port == '0);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $countones({out_port, out_ur}) == 1);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_port == '0 && !out_ur));

  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && kind == PK_CPL && bus_hit[0] |=> out_port[1]);
endmodule

// File: tb/sim_sw_route_dec.sv
module sim_sw_route_dec;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int MW = 12;
  localparam int IW = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic in_vld;
  logic [1:0] in_kind;
  logic [IW-1:0] in_addr_hi;
  logic [7:0] in_bus;
  logic [MW-1:0] up_mem_lo, up_mem_hi;
  logic [IW-1:0] up_io_lo, up_io_hi;
  logic [MW-1:0] m_lo [N], m_hi [N];
  logic [IW-1:0] i_lo [N], i_hi [N];
  logic [7:0]    b_lo [N], b_hi [N];
  logic [N*MW-1:0] dn_mem_lo, dn_mem_hi;
  logic [N*IW-1:0] dn_io_lo, dn_io_hi;
  logic [N*8-1:0]  dn_bus_lo, dn_bus_hi;
  logic out_vld, out_ur;
  logic [N:0] out_port;

  int total = 0;
  int bad = 0;
  bit pend = 0;
  logic e_vld, e_ur;
  logic [N:0] e_port;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      dn_mem_lo[i*MW +: MW] = m_lo[i];
      dn_mem_hi[i*MW +: MW] = m_hi[i];
      dn_io_lo[i*IW +: IW]  = i_lo[i];
      dn_io_hi[i*IW +: IW]  = i_hi[i];
      dn_bus_lo[i*8 +: 8]   = b_lo[i];
      dn_bus_hi[i*8 +: 8]   = b_hi[i];
    end
  end

  sw_route_dec u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_kind(in_kind),
    .in_addr_hi(in_addr_hi), .in_bus(in_bus),
    .up_mem_lo(up_mem_lo), .up_mem_hi(up_mem_hi),
    .up_io_lo(up_io_lo), .up_io_hi(up_io_hi),
    .dn_mem_lo(dn_mem_lo), .dn_mem_hi(dn_mem_hi),
    .dn_io_lo(dn_io_lo), .dn_io_hi(dn_io_hi),
    .dn_bus_lo(dn_bus_lo), .dn_bus_hi(dn_bus_hi),
    .out_vld(out_vld), .out_port(out_port), .out_ur(out_ur));

  // Behavioural reference: integers and searches, no structure shared with the design
  task automatic model(input bit v, input int kind, input int addr_hi, input int bus,
                       output logic ov, output logic [N:0] op, output logic our,
                       output string tag);
    int key, lo, hi, hits, first;
    ov = v; op = '0; our = 1'b0; tag = "R9";
    if (!v) return;
    if (kind == 3) begin our = 1'b1; tag = "R8"; return; end
    if (kind == 2) begin
      first = -1;
      for (int i = N - 1; i >= 0; i--)
        if (int'(b_lo[i]) <= bus && bus <= int'(b_hi[i])) first = i;
      if (first >= 0) op[first + 1] = 1'b1; else op[0] = 1'b1;
      tag = "R5";
      return;
    end
    key = (kind == 0) ? (addr_hi / 256) : addr_hi;
    lo  = (kind == 0) ? int'(up_mem_lo) : int'(up_io_lo);
    hi  = (kind == 0) ? int'(up_mem_hi) : int'(up_io_hi);
    if (!(lo <= key && key <= hi)) begin op[0] = 1'b1; tag = "R3"; return; end
    hits = 0; first = -1;
    for (int i = N - 1; i >= 0; i--) begin
      lo = (kind == 0) ? int'(m_lo[i]) : int'(i_lo[i]);
      hi = (kind == 0) ? int'(m_hi[i]) : int'(i_hi[i]);
      if (lo <= key && key <= hi) begin hits++; first = i; end
    end
    if (first < 0) begin our = 1'b1; tag = "R4"; end
    else begin
      op[first + 1] = 1'b1;
      tag = (hits > 1) ? "R7" : ((kind == 0) ? "R1" : "R2");
    end
  endtask

  task automatic compare();
    if (!pend) return;
    total++;
    if (out_vld !== e_vld || out_port !== e_port || out_ur !== e_ur) begin
      bad++;
      $display("FAIL %s: got vld=%0b port=%b ur=%0b expected vld=%0b port=%b ur=%0b",
               e_tag, out_vld, out_port, out_ur, e_vld, e_port, e_ur);
    end
  endtask

  task automatic send(input bit v, input int kind, input int addr_hi, input int bus,
                      input string tag_ovr);
    @(negedge clk);
    compare();
    in_vld = v; in_kind = kind[1:0]; in_addr_hi = addr_hi[IW-1:0]; in_bus = bus[7:0];
    model(v, kind, addr_hi, bus, e_vld, e_port, e_ur, e_tag);
    if (tag_ovr != "") e_tag = tag_ovr;
    pend = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_kind = 2'd0; in_addr_hi = '0; in_bus = '0;
    up_mem_lo = 12'h100; up_mem_hi = 12'h3FF;
    up_io_lo  = 20'h00010; up_io_hi = 20'h000FF;
    m_lo[0] = 12'h100; m_hi[0] = 12'h1FF;
    m_lo[1] = 12'h200; m_hi[1] = 12'h27F;
    m_lo[2] = 12'h250; m_hi[2] = 12'h2FF;
    m_lo[3] = 12'h380; m_hi[3] = 12'h300;
    i_lo[0] = 20'h10; i_hi[0] = 20'h1F;
    i_lo[1] = 20'h20; i_hi[1] = 20'h3F;
    i_lo[2] = 20'h50; i_hi[2] = 20'h4F;
    i_lo[3] = 20'h40; i_hi[3] = 20'h4F;
    b_lo[0] = 8'd2;  b_hi[0] = 8'd4;
    b_lo[1] = 8'd5;  b_hi[1] = 8'd5;
    b_lo[2] = 8'd6;  b_hi[2] = 8'd9;
    b_lo[3] = 8'd12; b_hi[3] = 8'd10;
    in_vld = 1'b1; in_kind = 2'd3;
    repeat (3) @(negedge clk);
    total++;
    if (out_vld !== 1'b0 || out_port !== '0 || out_ur !== 1'b0) begin
      bad++;
      $display("FAIL R10: got vld=%0b port=%b ur=%0b expected vld=0 port=0 ur=0",
               out_vld, out_port, out_ur);
    end
    in_vld = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // memory, address bits [31:12] given; granule is the top 12 bits
    send(1, 0, 20'h10000, 0, "R1");
    send(1, 0, 20'h1FFFF, 0, "R1");
    send(1, 0, 20'h20000, 0, "R1");
    send(1, 0, 20'h26000, 0, "R7");
    send(1, 0, 20'h28000, 0, "R1");
    send(1, 0, 20'h38000, 0, "R6");
    send(1, 0, 20'h30000, 0, "R4");
    send(1, 0, 20'h0FFFF, 0, "R3");
    send(1, 0, 20'h40000, 0, "R3");
    // I/O
    send(1, 1, 20'h00010, 0, "R2");
    send(1, 1, 20'h0003F, 0, "R2");
    send(1, 1, 20'h00045, 0, "R2");
    send(1, 1, 20'h00050, 0, "R6");
    send(1, 1, 20'h0000F, 0, "R3");
    send(1, 1, 20'h00100, 0, "R3");
    send(1, 1, 20'h00060, 0, "R4");
    // completions
    send(1, 2, 0, 2, "R5");
    send(1, 2, 0, 4, "R5");
    send(1, 2, 0, 5, "R5");
    send(1, 2, 0, 9, "R5");
    send(1, 2, 0, 11, "R6");
    send(1, 2, 20'h10000, 0, "R5");
    send(1, 3, 20'h10000, 2, "R8");
    send(0, 0, 20'h10000, 0, "R9");
    send(1, 2, 0, 6, "R9");
    send(0, 3, 0, 0, "R9");
    // overlapping bus ranges
    send(0, 0, 0, 0, "R9");
    b_lo[1] = 8'd3; b_hi[1] = 8'd8;
    send(1, 2, 0, 4, "R7");
    send(1, 2, 0, 7, "R7");
    send(0, 0, 0, 0, "R9");
    b_lo[1] = 8'd5; b_hi[1] = 8'd5;
    // disabled upstream memory window
    up_mem_lo = 12'h200; up_mem_hi = 12'h1FF;
    send(1, 0, 20'h15000, 0, "R6");
    send(1, 0, 20'h20000, 0, "R6");
    send(0, 0, 0, 0, "R9");
    up_mem_lo = 12'h100; up_mem_hi = 12'h3FF;

    for (int n = 0; n < 3000; n++) begin
      int k;
      int a;
      k = $urandom_range(0, 3);
      if (k == 0) a = ($urandom_range(0, 12'h4FF) << 8) | $urandom_range(0, 255);
      else        a = $urandom_range(0, 20'h120);
      send($urandom_range(0, 7) != 0, k, a, $urandom_range(0, 15), "");
    end
    send(0, 0, 0, 0, "R9");
    @(negedge clk);
    compare();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule